// File: doc/BRIEF.md
# Accumulator ALU Instruction Executor

This block carries out the arithmetic and logic group of an 8-bit accumulator instruction set, one instruction per clock. The caller presents an opcode that has already been fetched, together with the immediate byte if the opcode has one, the contents of the working registers, the stack pointer, the byte read from memory at the address held in the HL pair, and the current flag vector. One cycle later the block returns a byte write (the target register, the accumulator or the memory byte at HL), a separate 16-bit write to HL, and the complete new flag vector.

Bits 5:3 of an accumulator-group opcode choose the operation and bits 2:0 choose the source, so one decoder field serves both. Compare runs the subtract path and drops the result. Single-byte increment and decrement use their own overflow rule and keep the carry. A 16-bit add into HL changes only the carry. The block also handles complement-accumulator, set-carry and complement-carry. Every other opcode passes through with no effect, which lets the block sit beside other execution units that share the same opcode stream.

Top module: `acc_alu_exec`

## Requirements
- R1: Opcodes 0x80 to 0xBF take the operation from bits 5:3 (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare) and the source from bits 2:0 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 the memory byte at HL, 7 A). Every operation except compare writes its result to the accumulator, signalled as wr_en=1 with wr_sel=7.
- R2: Flag vector layout: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. Add and subtract set sign from result bit 7. Zero is set for a zero result. Parity is set when the result has an even number of ones. Auxiliary carry is bit 4 of (A xor operand xor result). Overflow flags a signed overflow. Carry is the carry out of bit 7 for add and the borrow for subtract.
- R3: For add with carry and subtract with borrow, the incoming carry flag is added to the source first. The resulting 9-bit operand is then used for the sum or difference and for every flag formula.
- R4: Compare (opcode field 7, or immediate 0xFE) updates the flags exactly as subtract would and raises no write.
- R5: AND, XOR and OR set sign, zero and parity from the result and clear carry, auxiliary carry and overflow.
- R6: Opcode 0xC6 + 8*op (op 0 to 7) performs operation op of R1 on the immediate byte.
- R7: Opcode 0x04 + 8*r increments and 0x05 + 8*r decrements the byte selected by r using the R1 source map (6 = memory at HL). It writes the low byte back with wr_sel=r and keeps carry. Overflow is set only when the old value is 0x7F for increment or 0x80 for decrement. Auxiliary carry, sign, zero and parity follow R2.
- R8: Opcode 0x09 + 0x10*p adds pair p (0 BC, 1 DE, 2 HL, 3 SP) into HL. The block drives hl_we=1 with the low 16 bits, sets carry from bit 16, and leaves every other flag unchanged.
- R9: Opcode 0x2F writes the complement of A to the accumulator and leaves all flags unchanged.
- R10: Opcode 0x37 sets carry to 1 and opcode 0x3F inverts carry. Neither writes a register or touches any other flag.
- R11: Any other opcode raises no write and returns flags_out equal to flags_in.
- R12: Results appear on the clock edge that follows an in_valid cycle, together with out_valid. After reset every output is zero. In a cycle without in_valid, no write is raised and flags_out holds its value.
- R13: wr_en and hl_we are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Instruction byte |
| imm | input | DW | Byte following the opcode |
| reg_b | input | DW | Register B |
| reg_c | input | DW | Register C |
| reg_d | input | DW | Register D |
| reg_e | input | DW | Register E |
| reg_h | input | DW | Register H |
| reg_l | input | DW | Register L |
| reg_a | input | DW | Accumulator |
| sp_in | input | 2*DW | Stack pointer |
| mem_rdata | input | DW | Memory byte at address HL |
| flags_in | input | 6 | Current flags (layout in R2) |
| out_valid | output | 1 | Result outputs are valid |
| wr_en | output | 1 | Byte write request |
| wr_sel | output | 3 | Byte target, R1 source map |
| wr_data | output | DW | Byte to write |
| hl_we | output | 1 | HL pair write request |
| hl_data | output | 2*DW | New HL value |
| flags_out | output | 6 | New flag vector |

## Verification
The assertions assume that the opcode, operands and flags_in are stable and known in every cycle where in_valid is high, and that in_valid is itself never unknown outside reset. The bench drives all inputs on the falling edge and only from its own variables, so every assertion sample sees settled values. Random register contents, memory byte and incoming flags cover the whole byte range. Opcodes are either drawn from the classes the block decodes or taken at random across all 256 values. Directed cases add the exact overflow boundaries, a carry-in that lifts the operand to 0x100, and cycles with in_valid low.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int NF    = 6;
   localparam int F_CY  = 0;
   localparam int F_PF  = 1;
   localparam int F_AC  = 2;
   localparam int F_ZF  = 3;
   localparam int F_SF  = 4;
   localparam int F_OV  = 5;
   localparam int SEL_W = 3;
   localparam logic [SEL_W-1:0] SEL_ACC = 3'd7;
   localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

   typedef enum logic [3:0] {
      K_NONE, K_ADD, K_SUB, K_AND, K_XOR, K_OR,
      K_INC, K_DEC, K_WIDE, K_CPL, K_SETC, K_CMCY
   } kind_e;

   typedef struct packed {
      kind_e            kind;
      logic             use_cy;
      logic             wr;
      logic             use_imm;
      logic [SEL_W-1:0] src_sel;
      logic [SEL_W-1:0] dst_sel;
      logic [1:0]       pair_sel;
   } ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [7:0] opcode,
   output ctl_t       ctl
);

   logic acc_grp;
   logic imm_grp;

   assign acc_grp = (opcode[7:6] == 2'b10);
   assign imm_grp = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b110);

   always_comb begin
      ctl.kind     = K_NONE;
      ctl.use_cy   = 1'b0;
      ctl.wr       = 1'b0;
      ctl.use_imm  = 1'b0;
      ctl.src_sel  = opcode[2:0];
      ctl.dst_sel  = SEL_ACC;
      ctl.pair_sel = opcode[5:4];
      if (acc_grp || imm_grp) begin
         ctl.use_imm = imm_grp;
         ctl.wr      = 1'b1;
         unique case (opcode[5:3])
            3'd0: ctl.kind = K_ADD;
            3'd1: begin ctl.kind = K_ADD; ctl.use_cy = 1'b1; end
            3'd2: ctl.kind = K_SUB;
            3'd3: begin ctl.kind = K_SUB; ctl.use_cy = 1'b1; end
            3'd4: ctl.kind = K_AND;
            3'd5: ctl.kind = K_XOR;
            3'd6: ctl.kind = K_OR;
            3'd7: begin ctl.kind = K_SUB; ctl.wr = 1'b0; end
            default: ctl.kind = K_NONE;
         endcase
      end else if (opcode[7:6] == 2'b00) begin
         unique case (opcode[2:0])
            3'b100: begin
               ctl.kind = K_INC; ctl.wr = 1'b1;
               ctl.src_sel = opcode[5:3]; ctl.dst_sel = opcode[5:3];
            end
            3'b101: begin
               ctl.kind = K_DEC; ctl.wr = 1'b1;
               ctl.src_sel = opcode[5:3]; ctl.dst_sel = opcode[5:3];
            end
            3'b001: if (opcode[3]) ctl.kind = K_WIDE;
            3'b111: begin
               case (opcode[5:3])
                  3'b101: begin ctl.kind = K_CPL; ctl.wr = 1'b1; ctl.src_sel = SEL_ACC; end
                  3'b110: ctl.kind = K_SETC;
                  3'b111: ctl.kind = K_CMCY;
                  default: ctl.kind = K_NONE;
               endcase
            end
            default: ctl.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DW = 8
)(
   input  kind_e          kind,
   input  logic           use_cy,
   input  logic [DW-1:0]  lhs,
   input  logic [DW-1:0]  rhs,
   input  logic [NF-1:0]  fl_in,
   output logic [DW-1:0]  res,
   output logic [NF-1:0]  fl_out
);

   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};

   logic [DW:0]   eff;
   logic [DW+1:0] sum_w;
   logic [DW+1:0] dif_w;
   logic          cy, ac, ov, szp_upd;

   // operand widened by one bit so a carry-in on 0xFF becomes 0x100
   assign eff   = {1'b0, rhs} + {{DW{1'b0}}, use_cy & fl_in[F_CY]};
   assign sum_w = {2'b00, lhs} + {1'b0, eff};
   assign dif_w = {2'b00, lhs} - {1'b0, eff};

   always_comb begin
      res     = lhs;
      cy      = fl_in[F_CY];
      ac      = fl_in[F_AC];
      ov      = fl_in[F_OV];
      szp_upd = 1'b0;
      unique case (kind)
         K_ADD: begin
            res = sum_w[DW-1:0];
            cy  = sum_w[DW];
            ac  = lhs[4] ^ eff[4] ^ sum_w[4];
            ov  = (lhs[DW-1] == eff[DW-1]) && (sum_w[DW-1] != lhs[DW-1]);
            szp_upd = 1'b1;
         end
         K_SUB: begin
            res = dif_w[DW-1:0];
            cy  = dif_w[DW];
            ac  = lhs[4] ^ eff[4] ^ dif_w[4];
            ov  = (lhs[DW-1] != eff[DW-1]) && (dif_w[DW-1] != lhs[DW-1]);
            szp_upd = 1'b1;
         end
         K_AND, K_XOR, K_OR: begin
            if (kind == K_AND)      res = lhs & rhs;
            else if (kind == K_XOR) res = lhs ^ rhs;
            else                    res = lhs | rhs;
            cy = 1'b0; ac = 1'b0; ov = 1'b0;
            szp_upd = 1'b1;
         end
         K_INC: begin
            res = lhs + ONE;
            ac  = lhs[4] ^ res[4];
            ov  = (lhs == POS_MAX);
            szp_upd = 1'b1;
         end
         K_DEC: begin
            res = lhs - ONE;
            ac  = lhs[4] ^ res[4];
            ov  = (lhs == NEG_MIN);
            szp_upd = 1'b1;
         end
         K_CPL:  res = ~lhs;
         K_SETC: cy  = 1'b1;
         K_CMCY: cy  = ~fl_in[F_CY];
         default: ;
      endcase
   end

   always_comb begin
      fl_out       = fl_in;
      fl_out[F_CY] = cy;
      fl_out[F_AC] = ac;
      fl_out[F_OV] = ov;
      if (szp_upd) begin
         fl_out[F_SF] = res[DW-1];
         fl_out[F_ZF] = (res == '0);
         fl_out[F_PF] = ~^res;
      end
   end

endmodule

// File: rtl/acc_alu_wide.sv
module acc_alu_wide #(
   parameter int DW = 8
)(
   input  logic [1:0]       pair_sel,
   input  logic [DW-1:0]    reg_b,
   input  logic [DW-1:0]    reg_c,
   input  logic [DW-1:0]    reg_d,
   input  logic [DW-1:0]    reg_e,
   input  logic [DW-1:0]    reg_h,
   input  logic [DW-1:0]    reg_l,
   input  logic [2*DW-1:0]  sp_in,
   output logic [2*DW-1:0]  sum,
   output logic             cout
);

   localparam int PW = 2 * DW;

   logic [PW-1:0] pairs [4];
   logic [PW-1:0] addend;
   logic [PW:0]   full;

   assign pairs[0] = {reg_b, reg_c};
   assign pairs[1] = {reg_d, reg_e};
   assign pairs[2] = {reg_h, reg_l};
   assign pairs[3] = sp_in;

   assign addend = pairs[pair_sel];
   assign full   = {1'b0, reg_h, reg_l} + {1'b0, addend};
   assign sum    = full[PW-1:0];
   assign cout   = full[PW];

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
   import acc_alu_pkg::*;
#(
   parameter int DW      = 8,
   parameter bit OUT_REG = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       opcode,
   input  logic [DW-1:0]    imm,
   input  logic [DW-1:0]    reg_b,
   input  logic [DW-1:0]    reg_c,
   input  logic [DW-1:0]    reg_d,
   input  logic [DW-1:0]    reg_e,
   input  logic [DW-1:0]    reg_h,
   input  logic [DW-1:0]    reg_l,
   input  logic [DW-1:0]    reg_a,
   input  logic [2*DW-1:0]  sp_in,
   input  logic [DW-1:0]    mem_rdata,
   input  logic [NF-1:0]    flags_in,
   output logic             out_valid,
   output logic             wr_en,
   output logic [SEL_W-1:0] wr_sel,
   output logic [DW-1:0]    wr_data,
   output logic             hl_we,
   output logic [2*DW-1:0]  hl_data,
   output logic [NF-1:0]    flags_out
);

   localparam int PW = 2 * DW;
   localparam int NSRC = 1 << SEL_W;
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};

   if (DW < 5) begin : g_dw_bad
      $error("acc_alu_exec: DW must be at least 5 for the nibble carry");
   end

   ctl_t           ctl;
   logic [DW-1:0]  bank [NSRC];
   logic [DW-1:0]  operand;
   logic [DW-1:0]  lhs;
   logic [DW-1:0]  core_res;
   logic [NF-1:0]  core_fl;
   logic [PW-1:0]  wide_sum;
   logic           wide_cy;

   logic             n_wr_en;
   logic [SEL_W-1:0] n_wr_sel;
   logic [DW-1:0]    n_wr_data;
   logic             n_hl_we;
   logic [NF-1:0]    n_flags;

   acc_alu_decode u_dec (
      .opcode (opcode),
      .ctl    (ctl)
   );

   assign bank[0] = reg_b;
   assign bank[1] = reg_c;
   assign bank[2] = reg_d;
   assign bank[3] = reg_e;
   assign bank[4] = reg_h;
   assign bank[5] = reg_l;
   assign bank[6] = mem_rdata;
   assign bank[7] = reg_a;

   assign operand = ctl.use_imm ? imm : bank[ctl.src_sel];
   assign lhs     = (ctl.kind == K_INC || ctl.kind == K_DEC) ? operand : reg_a;

   acc_alu_core #(.DW(DW)) u_core (
      .kind   (ctl.kind),
      .use_cy (ctl.use_cy),
      .lhs    (lhs),
      .rhs    (operand),
      .fl_in  (flags_in),
      .res    (core_res),
      .fl_out (core_fl)
   );

   acc_alu_wide #(.DW(DW)) u_wide (
      .pair_sel (ctl.pair_sel),
      .reg_b    (reg_b),
      .reg_c    (reg_c),
      .reg_d    (reg_d),
      .reg_e    (reg_e),
      .reg_h    (reg_h),
      .reg_l    (reg_l),
      .sp_in    (sp_in),
      .sum      (wide_sum),
      .cout     (wide_cy)
   );

   always_comb begin
      n_wr_en   = in_valid && ctl.wr;
      n_wr_sel  = ctl.dst_sel;
      n_wr_data = core_res;
      n_hl_we   = in_valid && (ctl.kind == K_WIDE);
      n_flags   = core_fl;
      if (ctl.kind == K_WIDE) begin
         n_flags       = flags_in;
         n_flags[F_CY] = wide_cy;
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_sel    <= '0;
            wr_data   <= '0;
            hl_we     <= 1'b0;
            hl_data   <= '0;
            flags_out <= '0;
         end else begin
            out_valid <= in_valid;
            wr_en     <= n_wr_en;
            wr_sel    <= n_wr_sel;
            wr_data   <= n_wr_data;
            hl_we     <= n_hl_we;
            hl_data   <= wide_sum;
            if (in_valid) flags_out <= n_flags;
         end
      end

      // R12
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && !wr_en && !hl_we && $stable(flags_out)));
      // R12
      issue_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R4
      cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (opcode[7:3] == 5'b10111 || opcode == 8'hFE)) |=> !wr_en);
      // R5
      logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode[7:6] == 2'b10 && opcode[5] && opcode[4:3] != 2'b11)
         |=> (!flags_out[F_CY] && !flags_out[F_OV] && !flags_out[F_AC]));
      // R8
      wide_only_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode[7:6] == 2'b00 && opcode[3:0] == 4'h9)
         |=> (hl_we && flags_out[NF-1:1] == $past(flags_in[NF-1:1])));
      // R7
      incmem_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == 8'h34) |=> (flags_out[F_OV] == ($past(mem_rdata) == POS_MAX)));
      // R13
      excl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> !hl_we);
   end else begin : g_comb
      assign out_valid = in_valid;
      assign wr_en     = n_wr_en;
      assign wr_sel    = n_wr_sel;
      assign wr_data   = n_wr_data;
      assign hl_we     = n_hl_we;
      assign hl_data   = wide_sum;
      assign flags_out = n_flags;
   end

endmodule

// File: tb/acc_alu_exec_tb.sv
module acc_alu_exec_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_RAND     = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = 8'h00, imm = 8'h00;
   logic [7:0]  rb = 0, rc = 0, rd = 0, re = 0, rh = 0, rl = 0, ra = 0, mem = 0;
   logic [15:0] sp = 0;
   logic [5:0]  fin = 0;
   logic        out_valid, wr_en, hl_we;
   logic [2:0]  wr_sel;
   logic [7:0]  wr_data;
   logic [15:0] hl_data;
   logic [5:0]  flags_out;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu_exec dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .imm(imm),
      .reg_b(rb), .reg_c(rc), .reg_d(rd), .reg_e(re), .reg_h(rh), .reg_l(rl),
      .reg_a(ra), .sp_in(sp), .mem_rdata(mem), .flags_in(fin),
      .out_valid(out_valid), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .hl_we(hl_we), .hl_data(hl_data), .flags_out(flags_out)
   );

   function automatic int src_of(int idx);
      case (idx)
         0: return rb; 1: return rc; 2: return rd; 3: return re;
         4: return rh; 5: return rl; 6: return mem; default: return ra;
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] op);
      if (op[7:6] == 2'b10 || (op[7:6] == 2'b11 && op[2:0] == 3'b110)) begin
         if (op[5:3] == 3'd7) return "R4";
         if (op[5]) return "R5";
         if (op[6]) return "R6";
         if (op[3]) return "R3";
         return "R1/R2";
      end
      if (op[7:6] == 2'b00 && op[2:1] == 2'b10) return "R7";
      if (op[7:6] == 2'b00 && op[3:0] == 4'h9) return "R8";
      if (op == 8'h2F) return "R9";
      if (op == 8'h37 || op == 8'h3F) return "R10";
      return "R11";
   endfunction

   // {wr_en, wr_sel, wr_data, hl_we, hl_data, flags}
   function automatic logic [34:0] model();
      logic        we = 0, hwe = 0;
      logic [2:0]  sel = 0;
      logic [7:0]  res = 0;
      logic [15:0] hl = 0;
      logic [5:0]  f = fin;
      int a = ra, s, r, k, old, sum, cy = fin[0];
      if (opcode[7:6] == 2'b10 || (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110)) begin
         k = opcode[5:3];
         s = opcode[6] ? int'(imm) : src_of(opcode[2:0]);
         if (k == 1 || k == 3) s = s + cy;
         if (k <= 1) begin
            r = a + s; f[0] = (r > 255); f[2] = ((a ^ s ^ r) >> 4) & 1;
            f[5] = ((a ^ r) & (s ^ r) & 128) != 0;
         end else if (k == 4 || k == 5 || k == 6) begin
            r = (k == 4) ? (a & s) : (k == 5) ? (a ^ s) : (a | s);
            f[0] = 0; f[2] = 0; f[5] = 0;
         end else begin
            r = a - s; f[0] = (r < 0); f[2] = ((a ^ s ^ r) >> 4) & 1;
            f[5] = ((a ^ s) & (a ^ r) & 128) != 0;
         end
         res = r[7:0]; f[4] = res[7]; f[3] = (res == 0); f[1] = ~^res;
         we = (k != 7); sel = 7;
      end else if (opcode[7:6] == 2'b00 && opcode[2:1] == 2'b10) begin
         sel = opcode[5:3]; old = src_of(sel);
         r = opcode[0] ? old - 1 : old + 1;
         res = r[7:0];
         f[2] = ((old ^ int'(res)) >> 4) & 1;
         f[5] = opcode[0] ? (old == 128) : (old == 127);
         f[4] = res[7]; f[3] = (res == 0); f[1] = ~^res; we = 1;
      end else if (opcode[7:6] == 2'b00 && opcode[3:0] == 4'h9) begin
         case (opcode[5:4])
            2'd0: s = {rb, rc}; 2'd1: s = {rd, re};
            2'd2: s = {rh, rl}; default: s = sp;
         endcase
         sum = int'({rh, rl}) + s; hl = sum[15:0]; f[0] = sum[16]; hwe = 1;
      end else if (opcode == 8'h2F) begin
         we = 1; sel = 7; res = ~ra;
      end else if (opcode == 8'h37) f[0] = 1;
      else if (opcode == 8'h3F) f[0] = ~fin[0];
      return {we, sel, res, hwe, hl, f};
   endfunction

   task automatic check(string tag, logic [34:0] act, logic [34:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s op=%02h actual=%h expected=%h", tag, opcode, act, exp);
      end
   endtask

   task automatic rand_ops();
      {rb, rc, rd, re} = $urandom;
      {rh, rl, ra, mem} = $urandom;
      sp = $urandom; imm = $urandom; fin = $urandom;
   endtask

   task automatic step();
      logic [34:0] exp, act;
      in_valid = 1'b1;
      exp = model();
      @(negedge clk);
      act = {wr_en, wr_sel, wr_data, hl_we, hl_data, flags_out};
      if (!exp[34]) act[33:23] = '0;
      if (!exp[22]) act[21:6]  = '0;
      if (!exp[34]) exp[33:23] = '0;
      if (!exp[22]) exp[21:6]  = '0;
      check(tag_of(opcode), act, exp);
      check("R12", {34'd0, out_valid}, 35'd1);
      check("R13", {34'd0, wr_en & hl_we}, 35'd0);
   endtask

   task automatic idle();
      logic [5:0] held;
      held = flags_out;
      in_valid = 1'b0; opcode = $urandom; rand_ops();
      @(negedge clk);
      check("R12", {out_valid, wr_en, hl_we, flags_out}, {3'b000, held});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1357_2468));
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12", {out_valid, wr_en, wr_sel, wr_data, hl_we, hl_data, flags_out}, 36'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 boundaries on the memory byte and on a register
      rand_ops(); opcode = 8'h34; mem = 8'h7F; step();
      rand_ops(); opcode = 8'h35; mem = 8'h80; step();
      rand_ops(); opcode = 8'h35; mem = 8'h00; step();
      rand_ops(); opcode = 8'h3C; ra = 8'hFF; fin = 6'h01; step();
      // R3 carry-in lifting 0xFF to 0x100
      rand_ops(); opcode = 8'h88; rb = 8'hFF; fin = 6'h01; step();
      rand_ops(); opcode = 8'h9E; mem = 8'hFF; fin = 6'h01; ra = 8'h00; step();
      // R4 equal compare and R6 immediate compare
      rand_ops(); opcode = 8'hB9; rc = ra; step();
      rand_ops(); opcode = 8'hFE; imm = ra; step();
      // R2 signed overflow on add
      rand_ops(); opcode = 8'h80; ra = 8'h7F; rb = 8'h01; step();
      // R8 carry out of HL add
      rand_ops(); opcode = 8'h29; rh = 8'h80; rl = 8'h01; step();
      rand_ops(); opcode = 8'h39; rh = 8'hFF; rl = 8'hFF; sp = 16'h0001; step();
      // R9, R10, R11
      rand_ops(); opcode = 8'h2F; step();
      rand_ops(); opcode = 8'h37; fin = 6'h00; step();
      rand_ops(); opcode = 8'h3F; fin = 6'h2B; step();
      rand_ops(); opcode = 8'h76; step();
      rand_ops(); opcode = 8'h01; step();
      idle();

      for (int i = 0; i < N_RAND; i++) begin
         int cls;
         cls = $urandom_range(0, 7);
         rand_ops();
         case (cls)
            0, 1, 2: opcode = 8'h80 | 8'($urandom_range(0, 63));
            3:       opcode = 8'hC6 | {2'b00, 3'($urandom_range(0, 7)), 3'b000};
            4:       opcode = {2'b00, 3'($urandom_range(0, 7)), 2'b10, 1'($urandom_range(0, 1))};
            5:       opcode = {2'b00, 2'($urandom_range(0, 3)), 4'h9};
            default: opcode = 8'($urandom_range(0, 255));
         endcase
         step();
         if ((i % 97) == 0) idle();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule